// File: doc/BRIEF.md
# Deficit Connection-Hold Decision Unit

This unit sits at one input of a port-based crossbar scheduler that shares bandwidth by deficit round-robin. Every clock is one switch slot. When the input is idle and the accept stage hands it a one-hot choice of output, the unit registers that choice as the slot's decision. It credits the chosen output's signed deficit counter with that output's quota and starts holding the connection. While the connection is held, the counter loses one unit per slot. The connection is dropped in the first slot where the counter is negative and the cell crossing the switch ends a packet. Any negative balance left over is carried into the next match to that output.

Quotas, one per output, are written through a plain write port whenever reservations change. The unit works in two modes. In cell mode every cell counts as a packet end. In packet mode only the supplied last-cell flag counts. The keep-connected vector goes to the request logic, which uses it to keep the grant and accept stages away from a held connection.

Top module: `dcu_decision_unit`

## Requirements
- R1: After synchronous reset, `keep_conn` and `dec_q` are all zero and every deficit counter is zero.
- R2: A write with `qwr_en`=1 stores `qwr_val` as the quota of output `qwr_sel`. The most recent write is the value used by later matches.
- R3: When `keep_conn` is zero and `acc_oh` has exactly one bit set, the following cycle shows that one-hot value on both `dec_q` (for exactly one cycle) and `keep_conn`, and the chosen output's counter is credited with its quota.
- R4: In each slot a connection is held and not released, the held output's counter decreases by 1.
- R5: A held connection is released, and `keep_conn` goes to zero at that clock edge, when the held counter is negative and the slot's effective last-cell value is 1. The counter keeps its negative value for the next match.
- R6: In cell mode (`pkt_mode`=0) the last-cell value is taken as 1. With a credited balance v, the connection lasts v+2 cycles if v≥0 and 1 cycle if v<0.
- R7: In packet mode (`pkt_mode`=1) the connection is never released while `last_cell`=0, and the counter keeps decreasing while the unit waits.
- R8: `acc_oh` is ignored while a connection is held, and an `acc_oh` value that is not one-hot is ignored when idle: `dec_q` stays zero and `keep_conn` is unchanged.
- R9: A credit that would exceed 2^(QW-1)-1 saturates at that value. A decrement below -2^(QW-1) saturates at that value.
- R10: At most one bit of `keep_conn` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per switch slot |
| rst | input | 1 | Synchronous active-high reset |
| acc_oh | input | N | One-hot accept result for this slot |
| last_cell | input | 1 | Cell crossing this slot ends its packet (packet mode) |
| pkt_mode | input | 1 | 1 = packet mode, 0 = cell mode |
| qwr_en | input | 1 | Quota write strobe |
| qwr_sel | input | SELW | Output whose quota is written |
| qwr_val | input | QW | Unsigned quota value |
| dec_q | output | N | Registered decision, one-hot pulse on a new match |
| keep_conn | output | N | Held connection, one-hot or zero |

## Verification
Matches are repeated to one output in cell mode so that the carried negative balance changes the hold length from one match to the next. A zero quota gives the shortest two-cycle and one-cycle holds. Packet mode is tried with a delayed last-cell flag, which separates the hold driven by the counter from the hold driven by the packet boundary. A foreign accept during a hold, a multi-bit accept while idle, and a quota rewrite show that stray inputs are ignored. A maximal quota and a very long packet-mode wait drive the counter into both saturation limits. The effect of each limit shows up in the length of a later hold.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  typedef enum logic {
    MODE_CELL   = 1'b0,
    MODE_PACKET = 1'b1
  } hold_mode_e;
endpackage

// File: rtl/dcu_quota_bank.sv
module dcu_quota_bank #(
  parameter int N    = 4,
  parameter int QW   = 16,
  parameter int SELW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [QW-1:0]   wr_data,
  input  logic [SELW-1:0] rd_sel,
  output logic [QW-1:0]   rd_data
);
  logic [QW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_sel) < N))
      mem[wr_sel] <= wr_data;
  end

  assign rd_data = mem[rd_sel];
endmodule

// File: rtl/dcu_deficit_ctr.sv
module dcu_deficit_ctr #(
  parameter int QW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 credit_en,
  input  logic [QW-1:0]        credit_val,
  input  logic                 step_en,
  output logic signed [QW-1:0] cnt,
  output logic                 neg
);
  localparam int XW = QW + 2;
  localparam logic signed [XW-1:0] TOPV = {3'b000, {(QW-1){1'b1}}};
  localparam logic signed [XW-1:0] BOTV = {3'b111, {(QW-1){1'b0}}};
  localparam logic signed [XW-1:0] ONE  = 1;

  logic signed [XW-1:0] wide, plus, minus;

  always_comb begin
    wide  = {{2{cnt[QW-1]}}, cnt};
    plus  = wide + $signed({2'b00, credit_val});
    minus = wide - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (credit_en)
      cnt <= (plus > TOPV) ? TOPV[QW-1:0] : plus[QW-1:0];
    else if (step_en)
      cnt <= (minus < BOTV) ? BOTV[QW-1:0] : minus[QW-1:0];
  end

  assign neg = cnt[QW-1];
endmodule

// File: rtl/dcu_hold_ctrl.sv
module dcu_hold_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] acc,
  input  logic         eff_last,
  input  logic [N-1:0] neg_vec,
  output logic [N-1:0] conn,
  output logic [N-1:0] dec,
  output logic [N-1:0] credit_vec,
  output logic [N-1:0] step_vec
);
  logic one_ok, held, release_now, take;

  always_comb begin
    one_ok      = (acc != '0) && ((acc & (acc - N'(1))) == '0);
    held        = |conn;
    release_now = held && (|(conn & neg_vec)) && eff_last;
    take        = !held && one_ok;
    credit_vec  = take ? acc : '0;
    step_vec    = (held && !release_now) ? conn : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conn <= '0;
      dec  <= '0;
    end else begin
      dec <= take ? acc : '0;
      if (take)
        conn <= acc;
      else if (release_now)
        conn <= '0;
    end
  end
endmodule

// File: rtl/dcu_decision_unit.sv
module dcu_decision_unit
  import dcu_pkg::*;
#(
  parameter int N    = 4,
  parameter int QW   = 16,
  parameter int SELW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    acc_oh,
  input  logic            last_cell,
  input  logic            pkt_mode,
  input  logic            qwr_en,
  input  logic [SELW-1:0] qwr_sel,
  input  logic [QW-1:0]   qwr_val,
  output logic [N-1:0]    dec_q,
  output logic [N-1:0]    keep_conn
);
  hold_mode_e      mode;
  logic            eff_last;
  logic [SELW-1:0] acc_idx;
  logic [QW-1:0]   quota_rd;
  logic [N-1:0]    neg_vec, credit_vec, step_vec;

  always_comb begin
    mode     = hold_mode_e'(pkt_mode);
    eff_last = (mode == MODE_CELL) ? 1'b1 : last_cell;
    acc_idx  = '0;
    for (int i = 0; i < N; i++)
      if (acc_oh[i]) acc_idx = SELW'(i);
  end

  dcu_quota_bank #(.N(N), .QW(QW), .SELW(SELW)) u_quota (
    .clk(clk), .wr_en(qwr_en), .wr_sel(qwr_sel), .wr_data(qwr_val),
    .rd_sel(acc_idx), .rd_data(quota_rd)
  );

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic signed [QW-1:0] cnt_g;
    dcu_deficit_ctr #(.QW(QW)) u_ctr (
      .clk(clk), .rst(rst), .credit_en(credit_vec[g]), .credit_val(quota_rd),
      .step_en(step_vec[g]), .cnt(cnt_g), .neg(neg_vec[g])
    );
  end

  dcu_hold_ctrl #(.N(N)) u_hold (
    .clk(clk), .rst(rst), .acc(acc_oh), .eff_last(eff_last), .neg_vec(neg_vec),
    .conn(keep_conn), .dec(dec_q), .credit_vec(credit_vec), .step_vec(step_vec)
  );
endmodule

// File: rtl/dcu_decision_unit_chk.sv
module dcu_decision_unit_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] acc_oh,
  input logic         last_cell,
  input logic         pkt_mode,
  input logic [N-1:0] dec_q,
  input logic [N-1:0] keep_conn
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (keep_conn == '0 && dec_q == '0));

  assert_new_match_R3: assert property (@(posedge clk) disable iff (rst)
    (keep_conn == '0 && $countones(acc_oh) == 1) |=> (dec_q == $past(acc_oh)));

  assert_dec_follows_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_q != '0) |-> (keep_conn == dec_q && $past(keep_conn) == '0));

  assert_pkt_no_release_R7: assert property (@(posedge clk) disable iff (rst)
    (keep_conn != '0 && pkt_mode && !last_cell) |=> (keep_conn == $past(keep_conn)));

  assert_no_switch_R8: assert property (@(posedge clk) disable iff (rst)
    (keep_conn != '0) |=> (keep_conn == '0 || keep_conn == $past(keep_conn)));

  assert_single_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(keep_conn));
endmodule

bind dcu_decision_unit dcu_decision_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .acc_oh(acc_oh), .last_cell(last_cell),
  .pkt_mode(pkt_mode), .dec_q(dec_q), .keep_conn(keep_conn)
);

// File: tb/dcu_decision_unit_test.sv
`timescale 1ns/1ps
module dcu_decision_unit_test;
  localparam int N = 4, QW = 16, SELW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] acc_oh = '0;
  logic last_cell = 1'b0, pkt_mode = 1'b0, qwr_en = 1'b0;
  logic [SELW-1:0] qwr_sel = '0;
  logic [QW-1:0] qwr_val = '0;
  logic [N-1:0] dec_q, keep_conn;

  always #2.5 clk = ~clk;

  dcu_decision_unit #(.N(N), .QW(QW)) uut (
    .clk(clk), .rst(rst), .acc_oh(acc_oh), .last_cell(last_cell), .pkt_mode(pkt_mode),
    .qwr_en(qwr_en), .qwr_sel(qwr_sel), .qwr_val(qwr_val),
    .dec_q(dec_q), .keep_conn(keep_conn)
  );

  typedef struct { logic [N-1:0] port; int len; string tag; } exp_t;
  exp_t sbq[$];
  int errors = 0, checks = 0;
  int model_cnt[N];
  int quota_m[N];
  logic [N-1:0] cur = '0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat_q(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic wr_quota(int p, int val);
    @(negedge clk);
    qwr_en = 1'b1; qwr_sel = SELW'(p); qwr_val = QW'(val);
    @(negedge clk);
    qwr_en = 1'b0;
    quota_m[p] = val;
  endtask

  // Driver: models the expected hold length from the requirements and queues it.
  task automatic run_match(int p, bit pkt, int w, logic [N-1:0] spoil, string tag);
    exp_t e;
    int cnt, len, k;
    cnt = sat_q(model_cnt[p] + quota_m[p]);
    len = 0; k = 1;
    while (len == 0) begin
      if (cnt < 0 && (!pkt || k > w)) len = k;
      else begin cnt = sat_q(cnt - 1); k++; end
    end
    model_cnt[p] = cnt;
    e.port = N'(1) << p; e.len = len; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    pkt_mode = pkt; acc_oh = N'(1) << p; last_cell = !pkt;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      acc_oh = spoil; last_cell = !pkt || (j > w);
    end
    @(negedge clk);
    acc_oh = '0; last_cell = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: measures each hold and compares with the queued expectation.
  initial begin
    int len;
    exp_t e;
    len = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cur == '0) begin
          if (dec_q != '0) begin
            cur = dec_q; len = 1;
            chk(keep_conn == dec_q, "R3 keep equals decision", int'(keep_conn), int'(dec_q));
          end else if (keep_conn != '0)
            chk(1'b0, "R8 hold without decision", int'(keep_conn), 0);
        end else begin
          if (dec_q != '0) chk(1'b0, "R8 decision during hold", int'(dec_q), 0);
          if (keep_conn == cur) len++;
          else if (keep_conn == '0) begin
            if (sbq.size() == 0) chk(1'b0, "R3 unexpected match", int'(cur), 0);
            else begin
              e = sbq.pop_front();
              chk(cur == e.port, {e.tag, " port"}, int'(cur), int'(e.port));
              chk(len == e.len, {e.tag, " hold length"}, len, e.len);
            end
            cur = '0;
          end else begin
            chk(1'b0, "R10 held output switched", int'(keep_conn), int'(cur));
            cur = '0;
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin model_cnt[i] = 0; quota_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(keep_conn == '0, "R1 keep after reset", int'(keep_conn), 0);
    chk(dec_q == '0, "R1 dec after reset", int'(dec_q), 0);
    rst = 1'b0;
    // R2: load quotas
    wr_quota(0, 3); wr_quota(1, 0); wr_quota(2, 5); wr_quota(3, 1);
    // R1 zero counters, R6 cell mode: 3 -> 5 cycles
    run_match(0, 1'b0, 0, '0, "R6");
    // R4/R5 carried -1: 2 -> 4 cycles
    run_match(0, 1'b0, 0, '0, "R4");
    run_match(1, 1'b0, 0, '0, "R3");
    // R5: balance -1 after zero credit -> 1 cycle
    run_match(1, 1'b0, 0, '0, "R5");
    // R8: multi-bit accept while idle is ignored
    @(negedge clk); acc_oh = 4'b0011;
    @(negedge clk); acc_oh = '0;
    chk(dec_q == '0, "R8 multi-bit accept dec", int'(dec_q), 0);
    chk(keep_conn == '0, "R8 multi-bit accept keep", int'(keep_conn), 0);
    // R8: foreign accept during hold is ignored
    run_match(2, 1'b0, 0, 4'b1000, "R8");
    // R2: rewritten quota is used
    wr_quota(2, 2);
    run_match(2, 1'b0, 0, '0, "R2");
    // R7: packet mode waits for last cell
    run_match(3, 1'b1, 6, '0, "R7");
    run_match(3, 1'b1, 0, '0, "R7");
    // R9: upper saturation
    wr_quota(1, 65535);
    run_match(1, 1'b0, 0, '0, "R9");
    // R9: lower saturation, observed by the following short hold
    wr_quota(0, 0);
    run_match(0, 1'b1, 33000, '0, "R9");
    wr_quota(0, 5);
    run_match(0, 1'b0, 0, '0, "R9");
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R3 all matches observed", sbq.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule